// File: doc/BRIEF.md
# Interrupt Status Queue with Event Counters

This block collects status from five sources and hands it to a host through one read port, as 16-bit tagged report words. Three sources are event registers for the receive path, the transmit path and buffer management. Each has ten sticky bits that are set by one-cycle pulses from the datapath. The other two sources are 10-bit counters, one for missed frames and one for collisions. Each counter advances by one on an increment pulse.

The host usually pops the queue. Each pop returns the highest-priority source that has something to report, and clears that source. A pop that returns 0000h tells the host the queue is empty. The host can also read a chosen source directly, which clears it in the same way. A level interrupt request stays high while any source has an enabled report pending.

Top module: `evt_status_queue`

## Requirements
- R1: A read is taken on a clock edge where `rd_en` is high. From the next cycle on, `rd_data` holds the returned word until the next read. Bits 5:0 hold the source tag and bits 15:6 hold the ten content bits.
- R2: The source tags are 04h for receive events, 08h for transmit events, 0Ch for buffer events, 10h for the missed-frame counter and 12h for the collision counter.
- R3: A queue pop uses `rd_src` = 0. It returns the pending source with the highest priority, in this order from highest: receive, transmit, buffer, missed-frame counter, collision counter.
- R4: A queue pop with no source pending returns 0000h and clears nothing.
- R5: Event bits are sticky and collect their set pulses whether or not they are enabled. An event source is pending only when at least one of its bits is set together with the matching bit of its enable vector.
- R6: Reading an event source returns all ten bits and clears them, whether the read is a queue pop or a direct read. A set pulse that arrives in the same cycle as the clearing read is kept in the register.
- R7: Each counter advances by one per increment pulse and stops at 1023. It is pending when its bit 9 is set and its enable is high. Reading it returns the count and sets the count to zero, or to one if an increment arrives in the same cycle.
- R8: A direct read uses `rd_src` 1 to 5, for receive, transmit, buffer, missed-frame and collision in that order. It returns that source's word and clears the source whether or not the source is pending. Codes 6 and 7 return 0000h and change no state.
- R9: `irq` is high exactly when at least one source is pending. It follows the register state with no added delay.
- R10: While `rst` is high, all event bits and counts clear, `rd_data` is 0000h and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_evt_set | input | 10 | Receive event set pulses |
| tx_evt_set | input | 10 | Transmit event set pulses |
| buf_evt_set | input | 10 | Buffer event set pulses |
| rx_ie | input | 10 | Receive event enables |
| tx_ie | input | 10 | Transmit event enables |
| buf_ie | input | 10 | Buffer event enables |
| miss_inc | input | 1 | Missed-frame counter increment |
| coll_inc | input | 1 | Collision counter increment |
| miss_ie | input | 1 | Missed-frame counter report enable |
| coll_ie | input | 1 | Collision counter report enable |
| rd_en | input | 1 | Read strobe |
| rd_src | input | 3 | 0 = queue pop, 1 to 5 = direct source read |
| rd_data | output | 16 | Tagged report word of the last read |
| irq | output | 1 | Interrupt request level |

## Verification
The bench drives random traffic. Sparse event pulses go into all three registers, with enables that change partway through, and increment pulses go into both counters. Pops and direct reads are mixed into the same traffic. A bench model derived from the requirements predicts every read word and the `irq` level. This separates errors in priority order from errors in tag coding, and separates missing clears from lost same-cycle events. Directed cases cover several points:
- a pop on an empty queue;
- enables held low while bits collect, which shows gating apart from storage;
- a set pulse on the exact clearing edge;
- a counter driven past 1023, which tests the saturation point and the half-scale trigger;
- the two unused read codes.

// File: rtl/esq_pkg.sv
package esq_pkg;
    localparam int CONTENT_W = 10;
    localparam int TAG_W     = 6;
    localparam int WORD_W    = CONTENT_W + TAG_W;
    localparam int SRC_N     = 5;
    localparam int EVT_N     = 3;
    localparam int SEL_W     = 3;

    localparam logic [SEL_W-1:0] RD_QUEUE = '0;

    typedef struct packed {
        logic [CONTENT_W-1:0] body;
        logic [TAG_W-1:0]     tag;
    } report_t;

    function automatic logic [TAG_W-1:0] src_tag(input int idx);
        case (idx)
            0:       return 6'h04;
            1:       return 6'h08;
            2:       return 6'h0C;
            3:       return 6'h10;
            4:       return 6'h12;
            default: return 6'h00;
        endcase
    endfunction
endpackage

// File: rtl/esq_event_reg.sv
module esq_event_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] bits_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bits_o <= '0;
        end else if (clr_i) begin
            bits_o <= set_i;
        end else begin
            bits_o <= bits_o | set_i;
        end
    end
endmodule

// File: rtl/esq_sat_counter.sv
module esq_sat_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= inc_i ? W'(1) : '0;
        end else if (inc_i && cnt_o != CNT_MAX) begin
            cnt_o <= cnt_o + W'(1);
        end
    end
endmodule

// File: rtl/esq_prio_pick.sv
module esq_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    always_comb begin
        gnt_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                gnt_o = '0;
                gnt_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/evt_status_queue.sv
module evt_status_queue
    import esq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [9:0]  rx_evt_set,
    input  logic [9:0]  tx_evt_set,
    input  logic [9:0]  buf_evt_set,
    input  logic [9:0]  rx_ie,
    input  logic [9:0]  tx_ie,
    input  logic [9:0]  buf_ie,
    input  logic        miss_inc,
    input  logic        coll_inc,
    input  logic        miss_ie,
    input  logic        coll_ie,
    input  logic        rd_en,
    input  logic [2:0]  rd_src,
    output logic [15:0] rd_data,
    output logic        irq
);
    localparam int CNT_N = SRC_N - EVT_N;

    logic [EVT_N-1:0][CONTENT_W-1:0] evt_set, evt_ie;
    logic [CNT_N-1:0]                cnt_inc, cnt_ie;
    logic [SRC_N-1:0][CONTENT_W-1:0] body;
    logic [SRC_N-1:0]                pend, gnt, sel, clr;
    report_t                         word_nxt;

    assign evt_set = {buf_evt_set, tx_evt_set, rx_evt_set};
    assign evt_ie  = {buf_ie, tx_ie, rx_ie};
    assign cnt_inc = {coll_inc, miss_inc};
    assign cnt_ie  = {coll_ie, miss_ie};

    for (genvar g = 0; g < EVT_N; g++) begin : g_evt
        esq_event_reg #(.W(CONTENT_W)) u_reg (
            .clk   (clk),
            .rst   (rst),
            .set_i (evt_set[g]),
            .clr_i (clr[g]),
            .bits_o(body[g])
        );
        assign pend[g] = |(body[g] & evt_ie[g]);
    end

    for (genvar c = 0; c < CNT_N; c++) begin : g_cnt
        esq_sat_counter #(.W(CONTENT_W)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .inc_i(cnt_inc[c]),
            .clr_i(clr[EVT_N+c]),
            .cnt_o(body[EVT_N+c])
        );
        assign pend[EVT_N+c] = body[EVT_N+c][CONTENT_W-1] & cnt_ie[c];
    end

    esq_prio_pick #(.N(SRC_N)) u_pick (
        .req_i(pend),
        .gnt_o(gnt)
    );

    // Queue pop follows the grant; a direct code selects one source outright.
    always_comb begin
        sel = '0;
        if (rd_src == RD_QUEUE) begin
            sel = gnt;
        end else begin
            for (int i = 0; i < SRC_N; i++) begin
                if (rd_src == SEL_W'(i + 1)) sel[i] = 1'b1;
            end
        end
    end

    assign clr = rd_en ? sel : '0;

    always_comb begin
        word_nxt = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (sel[i]) begin
                word_nxt.body = body[i];
                word_nxt.tag  = src_tag(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= word_nxt;
        end
    end

    assign irq = |pend;
endmodule

// File: rtl/esq_checker.sv
module esq_checker (
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic [2:0]  rd_src,
    input logic [15:0] rd_data,
    input logic        irq,
    input logic [9:0]  rx_evt_set,
    input logic [4:0]  pend,
    input logic [4:0]  clr,
    input logic [9:0]  rx_body,
    input logic [9:0]  miss_cnt
);
    p_empty_pop_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_src == 3'd0 && !irq) |=> (rd_data == 16'h0000));

    p_rx_first_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_src == 3'd0 && pend[0]) |=> (rd_data[5:0] == 6'h04));

    p_pop_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_src == 3'd0 && irq) |=> (rd_data != 16'h0000));

    p_same_cycle_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_src == 3'd1) |=> (rx_body == $past(rx_evt_set)));

    p_count_no_drop_r7: assert property (@(posedge clk) disable iff (rst)
        !clr[3] |=> (miss_cnt >= $past(miss_cnt)));

    p_unused_code_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_src > 3'd5) |=> (rd_data == 16'h0000));
endmodule

bind evt_status_queue esq_checker u_esq_checker (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .rd_src    (rd_src),
    .rd_data   (rd_data),
    .irq       (irq),
    .rx_evt_set(rx_evt_set),
    .pend      (pend),
    .clr       (clr),
    .rx_body   (body[0]),
    .miss_cnt  (body[3])
);

// File: tb/tb_evt_status_queue.sv
`timescale 1ns/1ps
module tb_evt_status_queue;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  rx_evt_set = '0, tx_evt_set = '0, buf_evt_set = '0;
    logic [9:0]  rx_ie = '0, tx_ie = '0, buf_ie = '0;
    logic        miss_inc = 1'b0, coll_inc = 1'b0, miss_ie = 1'b0, coll_ie = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_src = '0;
    logic [15:0] rd_data;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [9:0]  m_ev [3];
    logic [9:0]  m_cnt [2];
    logic [15:0] m_rd;

    always #5 clk = ~clk;

    evt_status_queue dut (
        .clk(clk), .rst(rst),
        .rx_evt_set(rx_evt_set), .tx_evt_set(tx_evt_set), .buf_evt_set(buf_evt_set),
        .rx_ie(rx_ie), .tx_ie(tx_ie), .buf_ie(buf_ie),
        .miss_inc(miss_inc), .coll_inc(coll_inc),
        .miss_ie(miss_ie), .coll_ie(coll_ie),
        .rd_en(rd_en), .rd_src(rd_src),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [5:0] m_tag(input int k);
        case (k)
            0: return 6'h04;
            1: return 6'h08;
            2: return 6'h0C;
            3: return 6'h10;
            default: return 6'h12;
        endcase
    endfunction

    function automatic bit m_pend(input int k);
        case (k)
            0: return |(m_ev[0] & rx_ie);
            1: return |(m_ev[1] & tx_ie);
            2: return |(m_ev[2] & buf_ie);
            3: return m_cnt[0][9] & miss_ie;
            default: return m_cnt[1][9] & coll_ie;
        endcase
    endfunction

    function automatic bit m_irq();
        for (int k = 0; k < 5; k++) if (m_pend(k)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [9:0] m_body(input int k);
        return (k < 3) ? m_ev[k] : m_cnt[k-3];
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, update the model, then check after the edge.
    task automatic step(input logic [9:0] rs, ts, bs, input logic mi, ci, rv,
                        input logic [2:0] src, input string req);
        int pick;
        logic [9:0] sets [3];
        rx_evt_set = rs; tx_evt_set = ts; buf_evt_set = bs;
        miss_inc = mi; coll_inc = ci; rd_en = rv; rd_src = src;
        sets[0] = rs; sets[1] = ts; sets[2] = bs;
        pick = -1;
        if (rv) begin
            if (src == 3'd0) begin
                for (int k = 4; k >= 0; k--) if (m_pend(k)) pick = k;
            end else if (src <= 3'd5) begin
                pick = int'(src) - 1;
            end
            m_rd = (pick >= 0) ? {m_body(pick), m_tag(pick)} : 16'h0000;
        end
        for (int k = 0; k < 3; k++)
            m_ev[k] = ((pick == k) ? 10'h000 : m_ev[k]) | sets[k];
        for (int c = 0; c < 2; c++) begin
            logic inc;
            inc = (c == 0) ? mi : ci;
            if (pick == c + 3) m_cnt[c] = inc ? 10'd1 : 10'd0;
            else if (inc && m_cnt[c] != 10'h3FF) m_cnt[c] = m_cnt[c] + 10'd1;
        end
        @(negedge clk);
        check(req, rd_data, m_rd);
        check("R9", {15'd0, irq}, {15'd0, m_irq()});
    endtask

    task automatic idle(input string req);
        step('0, '0, '0, 1'b0, 1'b0, 1'b0, 3'd0, req);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 3; k++) m_ev[k] = '0;
        m_cnt[0] = '0; m_cnt[1] = '0; m_rd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", rd_data, 16'h0000);
        check("R10", {15'd0, irq}, 16'h0000);
        rst = 1'b0;

        // R4: empty pop returns zero
        step('0, '0, '0, 0, 0, 1, 3'd0, "R4");
        // R5: bits collect while disabled, no interrupt
        step(10'h021, 10'h100, '0, 0, 0, 0, 3'd0, "R5");
        check("R5", {15'd0, irq}, 16'h0000);
        // R5: enabling raises irq without new events
        rx_ie = 10'h001; tx_ie = 10'h100;
        idle("R5");
        check("R5", {15'd0, irq}, 16'h0001);
        // R3/R1/R2: receive first, full body, tag 04h
        step('0, '0, '0, 0, 0, 1, 3'd0, "R3");
        check("R1", rd_data, {10'h021, 6'h04});
        // R6: transmit pop with a new transmit event on the clearing edge
        step('0, 10'h002, '0, 0, 0, 1, 3'd0, "R6");
        check("R2", {10'd0, rd_data[5:0]}, 16'h0008);
        tx_ie = 10'h002;
        idle("R6");
        // R8: unused code has no effect, then direct read of transmit
        step('0, '0, '0, 0, 0, 1, 3'd6, "R8");
        step('0, '0, '0, 0, 0, 1, 3'd7, "R8");
        step('0, '0, '0, 0, 0, 1, 3'd2, "R8");
        check("R8", rd_data, {10'h002, 6'h08});
        // R7: counter saturates and reports at half scale
        miss_ie = 1'b1;
        for (int i = 0; i < 1100; i++) step('0, '0, '0, 1, 0, 0, 3'd0, "R7");
        step('0, '0, '0, 1, 0, 1, 3'd0, "R7");
        check("R7", rd_data, {10'h3FF, 6'h10});
        step('0, '0, '0, 0, 0, 1, 3'd4, "R7");
        check("R7", rd_data, {10'h001, 6'h10});
        // R2: collision tag through a direct read
        step('0, '0, '0, 0, 1, 1, 3'd5, "R2");
        step('0, '0, '0, 0, 0, 1, 3'd5, "R2");
        check("R2", rd_data, {10'h001, 6'h12});

        // Random traffic
        for (int n = 0; n < 6000; n++) begin
            logic [9:0] rs, ts, bs;
            logic [2:0] src;
            if (n % 500 == 0) begin
                rx_ie = 10'($urandom); tx_ie = 10'($urandom); buf_ie = 10'($urandom);
                miss_ie = 1'($urandom); coll_ie = 1'($urandom);
            end
            rs = ($urandom % 6 == 0) ? 10'(1 << ($urandom % 10)) : '0;
            ts = ($urandom % 6 == 0) ? 10'(1 << ($urandom % 10)) : '0;
            bs = ($urandom % 6 == 0) ? 10'(1 << ($urandom % 10)) : '0;
            src = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'd0;
            step(rs, ts, bs, 1'($urandom % 2), 1'($urandom % 2),
                 1'($urandom % 5 == 0), src, "R3/R6/R7");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule